// File: doc/BRIEF.md
# Dual-Mode Trigger Pulse Generator

This block drives a single trigger bit for an oscilloscope or communication analyzer. It runs on the same bit clock as a test-pattern generator. It has two modes. In divided-clock mode the output is a square wave at one eighth of the bit clock. In pattern mode the output is a wide pulse, locked to a chosen bit position inside the repeating test pattern. An analyzer can then trigger on the same point of every pattern repetition.

The pattern sequencer supplies a wrap strobe in the cycle that carries bit 0 of the pattern. The block counts bits from that strobe. It compares the count with the programmed position, after clamping the position to the pattern length. When they match, it starts a pulse that is high for exactly 64 bit periods. A match that arrives while a pulse is already high is ignored. A pattern shorter than 64 bits therefore gives one pulse spanning several repetitions. Any change of the mode input clears every counter, so the output never shows a runt pulse.

Top module: `trigger_pulse_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after reset, `trigOut` is 0 and the block is in divided-clock mode.
- R2: Divided-clock mode is selected by `modeSel`=0. In this mode `trigOut` repeats with a period of 8 clocks: 4 cycles low, then 4 cycles high. The first four cycles after reset or after entering the mode are low.
- R3: Pattern mode is selected by `modeSel`=1. The bit index is 0 in a cycle with `patWrap`=1, and otherwise one more than in the previous cycle. When the index equals the effective position, `trigOut` rises in the next cycle.
- R4: In pattern mode, each pulse stays high for exactly 64 consecutive cycles.
- R5: A position match that occurs while `trigOut` is high is ignored. With a pattern shorter than 64 bits, one pulse spans several repetitions. The next pulse starts at the first match after the output has fallen.
- R6: The effective position is `trigPos` when `trigPos` < `patLen`. Otherwise it is `patLen`−1.
- R7: A cycle in which `modeSel` differs from its value in the previous cycle forces `trigOut` to 0 in the next cycle. It also clears the divider, the pulse-width counter and the bit count.
- R8: After entering pattern mode, no pulse starts until the first cycle with `patWrap`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 1 | 0 = divided clock, 1 = pattern-locked pulse |
| trigPos | input | IDX_W | Bit position that starts the pulse |
| patLen | input | IDX_W | Pattern length in bits (at least 1) |
| patWrap | input | 1 | High in the cycle that carries pattern bit 0 |
| trigOut | output | 1 | Trigger output |

## Verification
The hardest case to reach is a position match that falls while a pulse is still high. Patterns shorter than the 64-cycle pulse force it, so the stimulus uses pattern lengths down to one bit. It also places mode switches in the middle of a pulse and in the middle of a divider period, to show that the clear removes partial pulses. Random positions beyond the pattern length exercise the clamp. Some segments drive irregular wrap strobes, so the bit count is restarted at points the position compare did not anticipate.

// File: rtl/trigpg_pkg.sv
package trigpg_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;      // mode changed: clear all counters and the output
    logic divRun;     // divided-clock mode is active
    logic pulseRun;   // pattern mode is active
    logic pulseLoad;  // start a new pulse
  } trigStrobe_t;
endpackage

// File: rtl/trigpg_ctrl.sv
module trigpg_ctrl
  import trigpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeSel,
  input  logic        patWrap,
  input  logic        hit,
  input  logic        busy,
  output trigStrobe_t strobe
);
  logic modeReg;
  logic synced;
  logic quiet;

  assign quiet = (modeSel == modeReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 1'b0;
      synced  <= 1'b0;
    end else begin
      modeReg <= modeSel;
      if (!quiet)
        synced <= 1'b0;
      else if (modeSel && patWrap)
        synced <= 1'b1;
    end
  end

  always_comb begin
    strobe.clear     = !quiet;
    strobe.divRun    = quiet && !modeSel;
    strobe.pulseRun  = quiet && modeSel;
    strobe.pulseLoad = quiet && modeSel && hit && (patWrap || synced) && !busy;
  end
endmodule

// File: rtl/trigpg_dp.sv
module trigpg_dp
  import trigpg_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int PULSE_W = 64,
  parameter int DIV     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] trigPos,
  input  logic [IDX_W-1:0] patLen,
  input  logic             patWrap,
  input  trigStrobe_t      strobe,
  output logic             hit,
  output logic             busy,
  output logic             trigOut
);
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(PULSE_W);
  localparam logic [DIV_W-1:0] HALF    = DIV_W'(DIV / 2);
  localparam logic [CNT_W-1:0] LOADVAL = CNT_W'(PULSE_W - 1);

  logic [IDX_W-1:0] idxReg, idxNow, posEff;
  logic [DIV_W-1:0] divCnt, divNext;
  logic [CNT_W-1:0] widthCnt;
  logic             outReg;

  assign idxNow  = patWrap ? '0 : idxReg + 1'b1;
  assign posEff  = (trigPos >= patLen) ? patLen - 1'b1 : trigPos;
  assign hit     = (idxNow == posEff);
  assign divNext = divCnt + 1'b1;
  assign busy    = outReg;
  assign trigOut = outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg   <= '0;
      divCnt   <= '0;
      widthCnt <= '0;
      outReg   <= 1'b0;
    end else if (strobe.clear) begin
      idxReg   <= '0;
      divCnt   <= '0;
      widthCnt <= '0;
      outReg   <= 1'b0;
    end else begin
      if (strobe.divRun) begin
        divCnt <= divNext;
        outReg <= (divNext >= HALF);
      end
      if (strobe.pulseRun) begin
        idxReg <= idxNow;
        if (outReg) begin
          if (widthCnt == '0) outReg <= 1'b0;
          else                widthCnt <= widthCnt - 1'b1;
        end else if (strobe.pulseLoad) begin
          outReg   <= 1'b1;
          widthCnt <= LOADVAL;
        end
      end
    end
  end
endmodule

// File: rtl/trigger_pulse_gen.sv
module trigger_pulse_gen
  import trigpg_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int PULSE_W = 64,
  parameter int DIV     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic [IDX_W-1:0] trigPos,
  input  logic [IDX_W-1:0] patLen,
  input  logic             patWrap,
  output logic             trigOut
);
  trigStrobe_t strobe;
  logic        hit;
  logic        busy;

  trigpg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .patWrap(patWrap),
    .hit(hit), .busy(busy), .strobe(strobe)
  );

  trigpg_dp #(.IDX_W(IDX_W), .PULSE_W(PULSE_W), .DIV(DIV)) u_dp (
    .clk(clk), .rstN(rstN), .trigPos(trigPos), .patLen(patLen),
    .patWrap(patWrap), .strobe(strobe), .hit(hit), .busy(busy),
    .trigOut(trigOut)
  );
endmodule

// File: rtl/trigpg_chk.sv
module trigpg_chk #(
  parameter int PULSE_W = 64,
  parameter int DIV     = 8
) (
  input logic clk,
  input logic rstN,
  input logic modeSel,
  input logic patWrap,
  input logic trigOut
);
  logic       lastMode;
  logic       quiet;
  logic       seenWrap;
  logic [7:0] highRun;

  assign quiet = (modeSel == lastMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastMode <= 1'b0;
      seenWrap <= 1'b0;
      highRun  <= '0;
    end else begin
      lastMode <= modeSel;
      if (!quiet)                    seenWrap <= 1'b0;
      else if (modeSel && patWrap)   seenWrap <= 1'b1;
      if (!trigOut)                  highRun <= '0;
      else if (highRun != 8'hFF)     highRun <= highRun + 1'b1;
    end
  end

  AST_DIV_HIGH_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigOut) && !$past(modeSel) && $past(quiet) |-> highRun == 8'(DIV / 2)); // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigOut) && $past(modeSel) && $past(quiet) |-> highRun == 8'(PULSE_W)); // R4

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !quiet |=> !trigOut); // R7

  AST_WAIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    modeSel && quiet && !seenWrap && !patWrap |=> !trigOut); // R8
endmodule

bind trigger_pulse_gen trigpg_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .patWrap(patWrap), .trigOut(trigOut)
);

// File: tb/trigger_pulse_gen_tb.sv
module trigger_pulse_gen_tb;
  localparam int IDX_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeSel = 1'b0;
  logic [IDX_W-1:0] trigPos = '0;
  logic [IDX_W-1:0] patLen = 16'd1;
  logic             patWrap = 1'b0;
  logic             trigOut;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    done    = 1'b0;

  // stimulus state
  int wrapLen = 1;
  int phase   = 0;
  int wrapMode = 0; // 0 none, 1 regular, 2 irregular

  // reference model state
  bit       mPrevMode = 0, mOut = 0, mSync = 0;
  int       mDiv = 0, mW = 0;
  int       mIdx = 0;

  always #5 clk = ~clk;

  trigger_pulse_gen #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .trigPos(trigPos),
    .patLen(patLen), .patWrap(patWrap), .trigOut(trigOut)
  );

  function automatic int effPos(int pos, int len); // R6
    return (pos >= len) ? len - 1 : pos;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPrevMode = 0; mOut = 0; mSync = 0; mDiv = 0; mW = 0; mIdx = 0;
    end else if (modeSel != mPrevMode) begin
      mPrevMode = modeSel; mOut = 0; mSync = 0; mDiv = 0; mW = 0; mIdx = 0;
    end else if (!modeSel) begin
      mDiv = (mDiv + 1) % 8;
      mOut = (mDiv >= 4);
    end else begin
      int  idxNow;
      bit  valid;
      idxNow = patWrap ? 0 : (mIdx + 1) % 65536;
      mIdx   = idxNow;
      valid  = patWrap || mSync;
      if (patWrap) mSync = 1;
      if (mOut) begin
        if (mW == 0) mOut = 0; else mW = mW - 1;
      end else if (valid && idxNow == effPos(int'(trigPos), int'(patLen))) begin
        mOut = 1; mW = 63;
      end
    end
  end

  task automatic check(input bit exp, input string req);
    nChecks++;
    if (trigOut !== exp) begin
      nFails++;
      $display("FAIL %s trigOut actual=%0b expected=%0b at %0t", req, trigOut, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(mOut, curReq);
      case (wrapMode)
        1: begin
          patWrap = (phase == 0);
          phase = (phase + 1 >= wrapLen) ? 0 : phase + 1;
        end
        2: patWrap = ($urandom % 40) == 0;
        default: patWrap = 1'b0;
      endcase
    end
  endtask

  task automatic setPattern(input int len, input int pos, input int wm);
    patLen  = IDX_W'(len);
    trigPos = IDX_W'(pos);
    wrapLen = len;
    phase   = 0;
    wrapMode = wm;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");

    // R2: divided clock right after reset, exact waveform
    curReq = "R2";
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      check(((k + 2) % 8) >= 4, "R2");
    end
    step(40);

    // R8: pattern mode, no wrap yet -> nothing
    curReq = "R8";
    setPattern(100, 5, 0);
    modeSel = 1'b1;
    step(300);
    check(1'b0, "R8");

    // R3/R4: regular pattern
    curReq = "R3";
    setPattern(100, 20, 1);
    step(400);
    curReq = "R4";
    setPattern(200, 150, 1);
    step(700);

    // R5: short patterns, matches while high ignored
    curReq = "R5";
    setPattern(10, 3, 1);
    step(400);
    setPattern(1, 0, 1);
    step(300);

    // R6: clamp
    curReq = "R6";
    setPattern(50, 500, 1);
    step(400);
    setPattern(70, 70, 1);
    step(400);

    // R7: mode switch mid pulse and mid divider period
    curReq = "R7";
    setPattern(100, 0, 1);
    step(30);
    modeSel = 1'b0;
    @(negedge clk); check(mOut, "R7");
    @(negedge clk); check(1'b0, "R7");
    step(13);
    modeSel = 1'b1;
    step(2);
    check(1'b0, "R7");
    step(200);
    modeSel = 1'b0;
    step(3);
    modeSel = 1'b1;
    step(150);

    // random segments
    for (int s = 0; s < 40; s++) begin
      int len, pos, wm;
      curReq = "R3";
      len = 1 + ($urandom % 150);
      pos = $urandom % (2 * len);
      wm  = (($urandom % 4) == 0) ? 2 : 1;
      if (pos >= len) curReq = "R6";
      if (len < 64)   curReq = "R5";
      setPattern(len, pos, wm);
      if (($urandom % 3) == 0) begin
        modeSel = ~modeSel;
        if (!modeSel) curReq = "R2";
      end
      step(200 + ($urandom % 800));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule